// File: doc/BRIEF.md
# Three-Phase Gate Deadtime Controller

This block sits between a PWM generator and the six gate drivers of a three-phase bridge. Each phase receives two active-low commands, one for the upper switch and one for the lower switch. The block turns them into two active-high gate enables. It applies three rules on the way:

- It never lets both switches of a phase conduct at once.
- It holds both switches off for a minimum number of clock cycles between one switch turning off and any switch of that phase turning on.
- It leaves gaps that are already long enough untouched.

A protection controller supplies one enable mask per output. The mask is applied last, so a trip removes a gate in the same cycle. A low mask also cancels any turn-on that is still waiting for its deadtime. Every phase is an instance of the same leg logic, so latencies and deadtimes match across phases and between the upper and lower side.

Decisions are registered once per clock. Turn-on and turn-off therefore share the same one-cycle latency, and a pulse keeps its commanded width except where deadtime is inserted.

Top module: `gdt_bridge`

## Requirements
- R1: Commands are inverting. With `cmd_hi_n`=0 and `cmd_lo_n`=1 the phase requests its upper output. With `cmd_hi_n`=1 and `cmd_lo_n`=0 it requests its lower output. A request that is allowed appears on the output one clock edge after it is sampled.
- R2: With both commands of a phase at 1, both outputs of that phase are off after the next edge.
- R3: With both commands of a phase at 0 (a clash), both outputs of that phase are off after the next edge.
- R4: The upper and lower outputs of one phase are never on at the same time.
- R5: After either output of a phase turns off, neither output of that phase turns on until both have been off for DT_CYC clock cycles. A request that arrives sooner is held back until that point.
- R6: When the commanded gap is DT_CYC cycles or longer, the turn-on happens one edge after the command, with no added delay. The output gap then equals the commanded gap.
- R7: Turn-off takes effect one edge after it is sampled, the same latency as turn-on. An upper or lower pulse that starts after a satisfied deadtime keeps its commanded width.
- R8: A low `en_hi` or `en_lo` bit forces the matching output off in the same cycle. While the bit is low, any pending delayed turn-on is cancelled. The mask removing a gate counts as a turn-off for the deadtime of R5.
- R9: Reset forces all outputs off. It also preloads the deadtime, so the first turn-on can occur no earlier than the DT_CYC-th edge after reset is released.
- R10: All phases behave identically and independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_n | input | NPH | Upper-switch commands, active low, one bit per phase |
| cmd_lo_n | input | NPH | Lower-switch commands, active low, one bit per phase |
| en_hi | input | NPH | Protection mask for the upper outputs, 1 = allowed |
| en_lo | input | NPH | Protection mask for the lower outputs, 1 = allowed |
| gate_hi | output | NPH | Upper gate enables, active high |
| gate_lo | output | NPH | Lower gate enables, active high |

## Verification
Command changes take effect one edge after they are sampled. Turn-on and turn-off have the same latency. A turn-on delayed by deadtime appears DT_CYC edges after the edge that removed the previous gate. A mask takes effect combinationally, within the same cycle.

The bench changes inputs on the falling edge and advances its reference model on the rising edge. It compares every output on the next falling edge. Its directed checks count off and on cycles between events to pin the R5, R6 and R7 widths exactly. The mask check samples one time unit after the mask drops, before any clock edge.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
  typedef enum logic [1:0] {
    LEG_IDLE  = 2'b00,
    LEG_UPPER = 2'b01,
    LEG_LOWER = 2'b10,
    LEG_CLASH = 2'b11
  } leg_req_e;

  // Active-low commands in, decoded request out.
  function automatic leg_req_e decode_req(input logic hi_n, input logic lo_n);
    leg_req_e r;
    unique case ({~lo_n, ~hi_n})
      2'b01:   r = LEG_UPPER;
      2'b10:   r = LEG_LOWER;
      2'b11:   r = LEG_CLASH;
      default: r = LEG_IDLE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gdt_decode.sv
module gdt_decode
  import gdt_pkg::*;
(
  input  logic hi_n,
  input  logic lo_n,
  output logic want_hi,
  output logic want_lo
);
  leg_req_e req;

  always_comb begin
    req     = decode_req(hi_n, lo_n);
    want_hi = (req == LEG_UPPER);
    want_lo = (req == LEG_LOWER);
  end
endmodule

// File: rtl/gdt_dead_timer.sv
module gdt_dead_timer #(
  parameter int DT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic off_evt,
  output logic ready
);
  localparam int CW = (DT_CYC > 1) ? $clog2(DT_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= LOAD;
    end else if (off_evt) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/gdt_leg.sv
module gdt_leg #(
  parameter int DT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_n,
  input  logic lo_n,
  input  logic en_hi,
  input  logic en_lo,
  output logic gate_hi,
  output logic gate_lo
);
  logic want_hi, want_lo;
  logic on_hi, on_lo;
  logic nxt_hi, nxt_lo;
  logic off_evt, ready;

  gdt_decode u_dec (
    .hi_n    (hi_n),
    .lo_n    (lo_n),
    .want_hi (want_hi),
    .want_lo (want_lo)
  );

  // A side may stay on, or start only when the opposite side is off
  // and the deadtime has run out.
  always_comb begin
    nxt_hi  = want_hi & en_hi & (on_hi | (~on_lo & ready));
    nxt_lo  = want_lo & en_lo & (on_lo | (~on_hi & ready));
    off_evt = (on_hi & ~nxt_hi) | (on_lo & ~nxt_lo);
  end

  gdt_dead_timer #(.DT_CYC(DT_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .off_evt (off_evt),
    .ready   (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      on_hi <= 1'b0;
      on_lo <= 1'b0;
    end else begin
      on_hi <= nxt_hi;
      on_lo <= nxt_lo;
    end
  end

  // Protection mask applied last, takes effect within the cycle.
  assign gate_hi = on_hi & en_hi;
  assign gate_lo = on_lo & en_lo;
endmodule

// File: rtl/gdt_bridge.sv
module gdt_bridge #(
  parameter int NPH    = 3,
  parameter int DT_CYC = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] cmd_hi_n,
  input  logic [NPH-1:0] cmd_lo_n,
  input  logic [NPH-1:0] en_hi,
  input  logic [NPH-1:0] en_lo,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  for (genvar p = 0; p < NPH; p++) begin : g_leg
    gdt_leg #(.DT_CYC(DT_CYC)) u_leg (
      .clk     (clk),
      .rst     (rst),
      .hi_n    (cmd_hi_n[p]),
      .lo_n    (cmd_lo_n[p]),
      .en_hi   (en_hi[p]),
      .en_lo   (en_lo[p]),
      .gate_hi (gate_hi[p]),
      .gate_lo (gate_lo[p])
    );
  end
endmodule

// File: rtl/gdt_bridge_chk.sv
module gdt_bridge_chk #(
  parameter int NPH    = 3,
  parameter int DT_CYC = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NPH-1:0] cmd_hi_n,
  input logic [NPH-1:0] cmd_lo_n,
  input logic [NPH-1:0] en_hi,
  input logic [NPH-1:0] en_lo,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo
);
  localparam int RW = $clog2(DT_CYC + 1) + 1;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [RW-1:0] run;

    // Counts sampled cycles in which both gates of the phase were off.
    always_ff @(posedge clk) begin
      if (rst) begin
        run <= '0;
      end else if (!gate_hi[p] && !gate_lo[p]) begin
        if (run < RW'(DT_CYC)) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[p] && gate_lo[p]));

    // R5
    dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p] || gate_lo[p]) |-> (run >= RW'(DT_CYC)));

    // R7
    hi_off_lat_chk: assert property (@(posedge clk) disable iff (rst)
      $past(cmd_hi_n[p]) |-> !gate_hi[p]);

    // R7
    lo_off_lat_chk: assert property (@(posedge clk) disable iff (rst)
      $past(cmd_lo_n[p]) |-> !gate_lo[p]);

    // R3
    clash_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!cmd_hi_n[p] && !cmd_lo_n[p]) |-> (!gate_hi[p] && !gate_lo[p]));

    // R8
    mask_cancel_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!en_hi[p]) |-> !gate_hi[p]);
  end
endmodule

bind gdt_bridge gdt_bridge_chk #(.NPH(NPH), .DT_CYC(DT_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_hi_n (cmd_hi_n),
  .cmd_lo_n (cmd_lo_n),
  .en_hi    (en_hi),
  .en_lo    (en_lo),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo)
);

// File: tb/sim_gdt_bridge.sv
module sim_gdt_bridge;
  localparam int CLK_NS = 10;
  localparam int NPH    = 3;
  localparam int DT     = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic [NPH-1:0] cmd_hi_n, cmd_lo_n, en_hi, en_lo;
  logic [NPH-1:0] gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit mh[NPH];
  bit ml[NPH];
  int z[NPH];

  always #(CLK_NS/2) clk = ~clk;

  gdt_bridge #(.NPH(NPH), .DT_CYC(DT)) u0 (
    .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .en_hi(en_hi), .en_lo(en_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Reference model: state changes on each rising edge.
  task automatic model_edge();
    for (int p = 0; p < NPH; p++) begin
      bit wh, wl, nh, nl;
      wh = !cmd_hi_n[p] && cmd_lo_n[p];
      wl = cmd_hi_n[p] && !cmd_lo_n[p];
      if (rst) begin
        mh[p] = 0; ml[p] = 0; z[p] = 0;
      end else begin
        nh = wh && en_hi[p] && (mh[p] || (!ml[p] && z[p] >= DT-1));
        nl = wl && en_lo[p] && (ml[p] || (!mh[p] && z[p] >= DT-1));
        if (!nh && !nl) z[p] = (!mh[p] && !ml[p]) ? ((z[p] < 1000) ? z[p] + 1 : z[p]) : 0;
        mh[p] = nh; ml[p] = nl;
      end
    end
  endtask

  task automatic check(string tag, bit cond, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int p = 0; p < NPH; p++) begin
      bit eh, el;
      eh = mh[p] & en_hi[p];
      el = ml[p] & en_lo[p];
      check({tag, " phase outputs"}, {gate_hi[p], gate_lo[p]} == {eh, el},
            {gate_hi[p], gate_lo[p]}, {eh, el});
      check("R4 overlap", !(gate_hi[p] && gate_lo[p]), {gate_hi[p], gate_lo[p]}, 0);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_cmd(int p, bit hn, bit ln);
    cmd_hi_n[p] = hn;
    cmd_lo_n[p] = ln;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    rst = 1; cmd_hi_n = '1; cmd_lo_n = '1; en_hi = '1; en_lo = '1;
    @(negedge clk);
    repeat (3) step("R9 reset");
    check("R9 reset outputs off", (gate_hi | gate_lo) == '0, gate_hi | gate_lo, 0);

    // R9: first turn-on no earlier than DT-th edge after release
    set_cmd(0, 0, 1);
    rst = 0;
    for (int k = 1; k <= DT; k++) begin
      step("R9");
      check("R9 preload", gate_hi[0] == (k == DT), gate_hi[0], k == DT);
    end

    // R1: lower request on phase 1 (deadtime already spent)
    set_cmd(1, 1, 0);
    step("R1");
    check("R1 lower on", gate_lo[1] == 1, gate_lo[1], 1);

    // R5: direct swap upper -> lower, both off exactly DT cycles
    set_cmd(0, 1, 0);
    cnt = 0;
    for (int k = 0; k < 3*DT; k++) begin
      step("R5");
      if (gate_lo[0]) break;
      if (!gate_hi[0]) cnt++;
    end
    check("R5 inserted gap", cnt == DT, cnt, DT);

    // R6: long commanded gap passes unchanged
    set_cmd(0, 1, 1);
    cnt = 0;
    for (int k = 0; k < DT+3; k++) begin
      step("R6");
      if (!gate_hi[0] && !gate_lo[0]) cnt++;
    end
    set_cmd(0, 0, 1);
    step("R6");
    if (!gate_hi[0]) cnt++;
    check("R6 gap unchanged", cnt == DT+3, cnt, DT+3);

    // R7: pulse width preserved
    set_cmd(0, 1, 1);
    repeat (DT+2) step("R7");
    set_cmd(0, 0, 1);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      step("R7");
      if (gate_hi[0]) cnt++;
    end
    set_cmd(0, 1, 1);
    for (int k = 0; k < 3; k++) begin
      step("R7");
      if (gate_hi[0]) cnt++;
    end
    check("R7 pulse width", cnt == 3, cnt, 3);

    // R2: idle gives both off
    check("R2 idle off", {gate_hi[0], gate_lo[0]} == 2'b00, {gate_hi[0], gate_lo[0]}, 0);

    // R3: clash while upper on
    set_cmd(0, 0, 1);
    repeat (DT+2) step("R3");
    set_cmd(0, 0, 0);
    step("R3");
    check("R3 clash off", {gate_hi[0], gate_lo[0]} == 2'b00, {gate_hi[0], gate_lo[0]}, 0);

    // R8: mask removes a gate in the same cycle
    set_cmd(2, 0, 1);
    repeat (DT+2) step("R8");
    en_hi[2] = 0;
    #1;
    check("R8 same-cycle mask", gate_hi[2] == 0, gate_hi[2], 0);
    en_lo[2] = 0;
    set_cmd(2, 1, 0);
    for (int k = 0; k < DT+3; k++) begin
      step("R8");
      check("R8 pending cancelled", gate_lo[2] == 0, gate_lo[2], 0);
    end
    en_lo[2] = 1; en_hi[2] = 1;
    step("R8");
    check("R8 resume", gate_lo[2] == 1, gate_lo[2], 1);
    // pending swap cancelled by mask inside deadtime
    set_cmd(2, 0, 1);
    en_hi[2] = 1;
    en_lo[2] = 0;
    repeat (2) step("R8");
    en_lo[2] = 1;
    repeat (DT+2) step("R8");

    // R10: random commands and masks on all phases
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NPH; p++) begin
        if ($urandom % 5 == 0) begin
          int v;
          v = $urandom % 4;
          set_cmd(p, v[0], v[1]);
        end
        en_hi[p] = ($urandom % 16) != 0;
        en_lo[p] = ($urandom % 16) != 0;
      end
      step("R10 random");
    end
    finish_run();
  end
endmodule